// File: doc/BRIEF.md
# Configuration Address/Data Access Decoder

This block gives a host I/O bus indirect access to the configuration spaces of many targets through two ports. The first port is a 32-bit address latch. Its top bit enables data accesses, and its other fields select a bus, a device/function slot and an aligned dword within the target's configuration space. The second port is a four-byte data window. A byte, word or dword access through the window is turned into a single target strobe. The strobe carries the bus and slot index, a byte offset, byte enables and lane-aligned write data. The target's read dword is then narrowed and shifted back to the requester.

Every request is accepted in the cycle it is presented. Its response comes out of a register one cycle later. A target counts as present only if its bit is set in a presence bitmap indexed by bus and slot. A window access is rejected if the latch is disabled, if the latch is misaligned, if the target is absent, or if the size and port offset form an illegal shape. A rejected write changes nothing, and a rejected read returns zero.

Top module: `cfg_access_decoder`

## Requirements
- R1: A dword write to the latch port (req_port_i = 0, size code 2) stores all 32 bits. A dword read of the latch port returns the last value stored.
- R2: A latch-port access whose size code is not 2 never changes the latch, and such a read returns zero.
- R3: A window access (req_port_i = 1) raises no target strobe when latch bit 31 is clear. Such a read returns zero.
- R4: A window access raises no target strobe when latch bits [1:0] are not both zero. Such a read returns zero.
- R5: The bus is taken from latch bits [23:16] and the slot from bits [15:8]. The strobe rises only when the bus is below 2^BUS_IDX_W and present_i bit {bus[BUS_IDX_W-1:0], slot} is set. Otherwise a read returns zero.
- R6: The target byte offset is {latch bits [7:2], req_addr_i[1:0]}.
- R7: Size codes are 0 = byte, 1 = word and 2 = dword. Byte enables are one, two or four consecutive lanes starting at req_addr_i. A word at port offset 3, a dword at a nonzero offset and size code 3 are all rejected with no strobe.
- R8: Write data is masked to the access size and shifted so that its byte 0 lands in lane req_addr_i. A window read returns the target bytes from lane req_addr_i upward in the low bytes of the result, little-endian, with the unused upper bytes zero.
- R9: req_ready_o is always high. rsp_valid_o is high exactly in the cycle after each accepted request. The response data of a write is zero.
- R10: Reset clears the latch, rsp_valid_o and rsp_rdata_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted (always high) |
| req_port_i | input | 1 | 0 = address latch, 1 = data window |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 2 | Byte offset within the port |
| req_size_i | input | 2 | 0 byte, 1 word, 2 dword, 3 reserved |
| req_wdata_i | input | 32 | Write data, right-aligned |
| rsp_valid_o | output | 1 | Response valid, one cycle after the request |
| rsp_rdata_o | output | 32 | Read data, right-aligned, zero for writes and rejects |
| present_i | input | 256*2^BUS_IDX_W | Target presence bitmap indexed by {bus, slot} |
| tgt_sel_o | output | 1 | Target access strobe |
| tgt_we_o | output | 1 | Target write strobe |
| tgt_bus_o | output | 8 | Selected bus number |
| tgt_devfn_o | output | 8 | Selected device/function slot |
| tgt_off_o | output | 8 | Configuration byte offset |
| tgt_be_o | output | 4 | Byte enables |
| tgt_wdata_o | output | 32 | Lane-aligned write data |
| tgt_rdata_i | input | 32 | Target dword at the aligned offset |

## Verification
The target returns a constant dword with a distinct value in each byte. A read at each port offset and size therefore shows exactly which lanes were picked and where they were placed. Writes use sub-dword sizes at high offsets, which separates size masking from lane shifting. The window is tried with a latch that is enabled, disabled and misaligned, pointing at a present slot, an absent slot and an out-of-range bus. Each of these cases is run after an accepted access, so a leak through any single gate shows up as a stray strobe or a nonzero read. Illegal shapes (word at offset 3, unaligned dword, reserved size) are placed between legal ones, which separates the shape check from the lane logic.

// File: rtl/cfg_access_pkg.sv
package cfg_access_pkg;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned LANES  = DATA_W / 8;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_RSVD  = 2'd3
  } acc_size_e;

  typedef enum logic {
    PORT_LATCH  = 1'b0,
    PORT_WINDOW = 1'b1
  } acc_port_e;

  // lanes covered by an access of this size, starting at lane 0
  function automatic logic [LANES-1:0] size_lanes(acc_size_e sz);
    case (sz)
      SZ_BYTE:  return LANES'(4'b0001);
      SZ_WORD:  return LANES'(4'b0011);
      SZ_DWORD: return LANES'(4'b1111);
      default:  return '0;
    endcase
  endfunction

  // size/offset combinations that stay within one dword
  function automatic logic shape_ok(acc_size_e sz, logic [1:0] off);
    case (sz)
      SZ_BYTE:  return 1'b1;
      SZ_WORD:  return off != 2'd3;
      SZ_DWORD: return off == 2'd0;
      default:  return 1'b0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] size_bits(acc_size_e sz);
    logic [LANES-1:0] l;
    logic [DATA_W-1:0] m;
    l = size_lanes(sz);
    for (int k = 0; k < int'(LANES); k++) m[8*k +: 8] = {8{l[k]}};
    return m;
  endfunction

endpackage

// File: rtl/cfg_addr_latch.sv
module cfg_addr_latch #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o,
  output logic         en_o,
  output logic         aligned_o,
  output logic [7:0]   bus_o,
  output logic [7:0]   devfn_o,
  output logic [5:0]   dw_off_o
);

  localparam int unsigned EN_BIT = W - 1;

  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= '0;
    else if (wr_i) q <= wdata_i;
  end

  assign q_o       = q;
  assign en_o      = q[EN_BIT];
  assign aligned_o = (q[1:0] == 2'b00);
  assign bus_o     = q[23:16];
  assign devfn_o   = q[15:8];
  assign dw_off_o  = q[7:2];

endmodule

// File: rtl/cfg_window_check.sv
module cfg_window_check
  import cfg_access_pkg::*;
#(
  parameter  int unsigned BUS_IDX_W = 1,
  localparam int unsigned NUM_TGT   = (1 << BUS_IDX_W) * 256,
  localparam int unsigned IDX_W     = BUS_IDX_W + 8
) (
  input  logic               en_i,
  input  logic               aligned_i,
  input  logic [7:0]         bus_i,
  input  logic [7:0]         devfn_i,
  input  logic [NUM_TGT-1:0] present_i,
  input  acc_size_e          size_i,
  input  logic [1:0]         addr_i,
  output logic               hit_o,
  output logic [LANES-1:0]   be_o
);

  logic             bus_in_range;
  logic [IDX_W-1:0] idx;
  logic             tgt_here;
  logic             shape;

  assign bus_in_range = ((bus_i >> BUS_IDX_W) == 8'd0);
  assign idx          = {bus_i[BUS_IDX_W-1:0], devfn_i};
  assign tgt_here     = bus_in_range && present_i[idx];
  assign shape        = shape_ok(size_i, addr_i);

  assign hit_o = en_i && aligned_i && tgt_here && shape;
  assign be_o  = shape ? (size_lanes(size_i) << addr_i) : '0;

endmodule

// File: rtl/cfg_lane_align.sv
module cfg_lane_align
  import cfg_access_pkg::*;
(
  input  logic [1:0]        addr_i,
  input  acc_size_e         size_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] lane_wdata_o,
  output logic [DATA_W-1:0] rdata_o
);

  logic [LANES-1:0] keep;
  logic [4:0]       shamt;

  assign keep         = size_lanes(size_i);
  assign shamt        = {addr_i, 3'b000};
  assign lane_wdata_o = (wdata_i & size_bits(size_i)) << shamt;

  // result byte k comes from target lane addr+k
  for (genvar k = 0; k < int'(LANES); k++) begin : g_rd_lane
    logic [2:0] src;
    assign src = 3'(k) + {1'b0, addr_i};
    always_comb begin
      rdata_o[8*k +: 8] = 8'h00;
      if (keep[k] && src < 3'(LANES)) rdata_o[8*k +: 8] = rdata_i[8*src[1:0] +: 8];
    end
  end

endmodule

// File: rtl/cfg_access_decoder.sv
module cfg_access_decoder
  import cfg_access_pkg::*;
#(
  parameter  int unsigned BUS_IDX_W = 1,
  localparam int unsigned NUM_TGT   = (1 << BUS_IDX_W) * 256
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic               req_port_i,
  input  logic               req_write_i,
  input  logic [1:0]         req_addr_i,
  input  logic [1:0]         req_size_i,
  input  logic [31:0]        req_wdata_i,
  output logic               rsp_valid_o,
  output logic [31:0]        rsp_rdata_o,
  input  logic [NUM_TGT-1:0] present_i,
  output logic               tgt_sel_o,
  output logic               tgt_we_o,
  output logic [7:0]         tgt_bus_o,
  output logic [7:0]         tgt_devfn_o,
  output logic [7:0]         tgt_off_o,
  output logic [3:0]         tgt_be_o,
  output logic [31:0]        tgt_wdata_o,
  input  logic [31:0]        tgt_rdata_i
);

  acc_size_e         sz;
  acc_port_e         port;
  logic              acc_latch, acc_win, latch_wr;
  logic [DATA_W-1:0] latch_q, latch_rd, win_rd, rd_next;
  logic              lat_en, lat_aligned, win_hit;
  logic [5:0]        lat_dw_off;
  logic [LANES-1:0]  win_be;

  assign sz          = acc_size_e'(req_size_i);
  assign port        = acc_port_e'(req_port_i);
  assign req_ready_o = 1'b1;
  assign acc_latch   = req_valid_i && (port == PORT_LATCH);
  assign acc_win     = req_valid_i && (port == PORT_WINDOW);
  assign latch_wr    = acc_latch && req_write_i && (sz == SZ_DWORD);

  cfg_addr_latch #(.W(DATA_W)) u_latch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (latch_wr),
    .wdata_i   (req_wdata_i),
    .q_o       (latch_q),
    .en_o      (lat_en),
    .aligned_o (lat_aligned),
    .bus_o     (tgt_bus_o),
    .devfn_o   (tgt_devfn_o),
    .dw_off_o  (lat_dw_off)
  );

  cfg_window_check #(.BUS_IDX_W(BUS_IDX_W)) u_check (
    .en_i      (lat_en),
    .aligned_i (lat_aligned),
    .bus_i     (tgt_bus_o),
    .devfn_i   (tgt_devfn_o),
    .present_i (present_i),
    .size_i    (sz),
    .addr_i    (req_addr_i),
    .hit_o     (win_hit),
    .be_o      (win_be)
  );

  cfg_lane_align u_align (
    .addr_i       (req_addr_i),
    .size_i       (sz),
    .wdata_i      (req_wdata_i),
    .rdata_i      (tgt_rdata_i),
    .lane_wdata_o (tgt_wdata_o),
    .rdata_o      (win_rd)
  );

  assign tgt_sel_o = acc_win && win_hit;
  assign tgt_we_o  = tgt_sel_o && req_write_i;
  assign tgt_off_o = {lat_dw_off, req_addr_i};
  assign tgt_be_o  = tgt_sel_o ? win_be : '0;

  assign latch_rd = (sz == SZ_DWORD) ? latch_q : '0;

  always_comb begin
    rd_next = '0;
    if (!req_write_i) begin
      if (port == PORT_LATCH) rd_next = latch_rd;
      else if (win_hit)       rd_next = win_rd;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) rsp_rdata_o <= rd_next;
    end
  end

endmodule

// File: rtl/cfg_access_checker.sv
module cfg_access_checker #(
  parameter  int unsigned BUS_IDX_W = 1,
  localparam int unsigned NUM_TGT   = (1 << BUS_IDX_W) * 256
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_valid_i,
  input logic               req_port_i,
  input logic               req_write_i,
  input logic [1:0]         req_addr_i,
  input logic [1:0]         req_size_i,
  input logic [NUM_TGT-1:0] present_i,
  input logic               tgt_sel_o,
  input logic [7:0]         tgt_bus_o,
  input logic [7:0]         tgt_devfn_o,
  input logic [7:0]         tgt_off_o,
  input logic [3:0]         tgt_be_o,
  input logic               rsp_valid_o,
  input logic [31:0]        rsp_rdata_o
);

  assert_sel_only_window_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_sel_o |-> (req_valid_i && req_port_i));

  assert_sel_target_present_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_sel_o |-> (((tgt_bus_o >> BUS_IDX_W) == 8'd0) &&
                   present_i[{tgt_bus_o[BUS_IDX_W-1:0], tgt_devfn_o}]));

  assert_off_low_bits_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_sel_o |-> (tgt_off_o[1:0] == req_addr_i));

  assert_be_lane_count_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_sel_o |-> ($countones(tgt_be_o) == 1 || $countones(tgt_be_o) == 2 ||
                   $countones(tgt_be_o) == 4));

  assert_dword_full_be_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tgt_sel_o && req_size_i == 2'd2) |-> (tgt_be_o == 4'hF));

  assert_rsp_after_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  assert_no_rsp_when_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);

  assert_write_rsp_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i) |=> (rsp_rdata_o == 32'd0));

endmodule

bind cfg_access_decoder cfg_access_checker #(.BUS_IDX_W(BUS_IDX_W)) u_cfg_access_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_port_i  (req_port_i),
  .req_write_i (req_write_i),
  .req_addr_i  (req_addr_i),
  .req_size_i  (req_size_i),
  .present_i   (present_i),
  .tgt_sel_o   (tgt_sel_o),
  .tgt_bus_o   (tgt_bus_o),
  .tgt_devfn_o (tgt_devfn_o),
  .tgt_off_o   (tgt_off_o),
  .tgt_be_o    (tgt_be_o),
  .rsp_valid_o (rsp_valid_o),
  .rsp_rdata_o (rsp_rdata_o)
);

// File: tb/tb_cfg_access_decoder.sv
`timescale 1ns/1ps
module tb_cfg_access_decoder;

  localparam int unsigned BUS_IDX_W = 1;
  localparam int unsigned NUM_TGT   = (1 << BUS_IDX_W) * 256;
  localparam logic [31:0] TGT_DATA  = 32'h4433_2211;

  logic               clk = 1'b0;
  logic               rst_ni = 1'b0;
  logic               req_valid_i = 1'b0;
  logic               req_ready_o;
  logic               req_port_i = 1'b0;
  logic               req_write_i = 1'b0;
  logic [1:0]         req_addr_i = '0;
  logic [1:0]         req_size_i = '0;
  logic [31:0]        req_wdata_i = '0;
  logic               rsp_valid_o;
  logic [31:0]        rsp_rdata_o;
  logic [NUM_TGT-1:0] present_i = '0;
  logic               tgt_sel_o, tgt_we_o;
  logic [7:0]         tgt_bus_o, tgt_devfn_o, tgt_off_o;
  logic [3:0]         tgt_be_o;
  logic [31:0]        tgt_wdata_o;
  logic [31:0]        tgt_rdata_i;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;
  assign tgt_rdata_i = TGT_DATA;

  cfg_access_decoder #(.BUS_IDX_W(BUS_IDX_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_port_i(req_port_i), .req_write_i(req_write_i),
    .req_addr_i(req_addr_i), .req_size_i(req_size_i), .req_wdata_i(req_wdata_i),
    .rsp_valid_o(rsp_valid_o), .rsp_rdata_o(rsp_rdata_o),
    .present_i(present_i),
    .tgt_sel_o(tgt_sel_o), .tgt_we_o(tgt_we_o),
    .tgt_bus_o(tgt_bus_o), .tgt_devfn_o(tgt_devfn_o), .tgt_off_o(tgt_off_o),
    .tgt_be_o(tgt_be_o), .tgt_wdata_o(tgt_wdata_o), .tgt_rdata_i(tgt_rdata_i)
  );

  typedef struct packed {
    logic [3:0]  rq;
    logic        port;
    logic        we;
    logic [1:0]  addr;
    logic [1:0]  size;
    logic [31:0] wdata;
    logic        sel;
    logic [3:0]  be;
    logic [7:0]  off;
    logic [15:0] idx;
    logic [31:0] twd;
    logic [31:0] rdata;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VEC [NV] = '{
    '{4'd1, 1'b0, 1'b1, 2'd0, 2'd2, 32'h8000_0814, 1'b0, 4'h0, 8'h00, 16'h0000, 32'h0, 32'h0},          // R1 latch write
    '{4'd1, 1'b0, 1'b0, 2'd0, 2'd2, 32'h0,         1'b0, 4'h0, 8'h00, 16'h0000, 32'h0, 32'h8000_0814}, // R1 latch read
    '{4'd8, 1'b1, 1'b0, 2'd0, 2'd0, 32'h0,         1'b1, 4'h1, 8'h14, 16'h0008, 32'h0, 32'h0000_0011}, // R8 byte lane 0
    '{4'd6, 1'b1, 1'b0, 2'd2, 2'd0, 32'h0,         1'b1, 4'h4, 8'h16, 16'h0008, 32'h0, 32'h0000_0033}, // R6 byte lane 2
    '{4'd7, 1'b1, 1'b0, 2'd1, 2'd1, 32'h0,         1'b1, 4'h6, 8'h15, 16'h0008, 32'h0, 32'h0000_3322}, // R7 word at 1
    '{4'd7, 1'b1, 1'b0, 2'd3, 2'd1, 32'h0,         1'b0, 4'h0, 8'h00, 16'h0000, 32'h0, 32'h0},          // R7 word at 3
    '{4'd8, 1'b1, 1'b0, 2'd0, 2'd2, 32'h0,         1'b1, 4'hF, 8'h14, 16'h0008, 32'h0, 32'h4433_2211}, // R8 dword
    '{4'd7, 1'b1, 1'b0, 2'd2, 2'd2, 32'h0,         1'b0, 4'h0, 8'h00, 16'h0000, 32'h0, 32'h0},          // R7 dword at 2
    '{4'd8, 1'b1, 1'b1, 2'd3, 2'd0, 32'h0000_00AB, 1'b1, 4'h8, 8'h17, 16'h0008, 32'hAB00_0000, 32'h0},  // R8 byte write
    '{4'd8, 1'b1, 1'b1, 2'd2, 2'd1, 32'hFFFF_CDEF, 1'b1, 4'hC, 8'h16, 16'h0008, 32'hCDEF_0000, 32'h0},  // R8 word write masked
    '{4'd7, 1'b1, 1'b0, 2'd0, 2'd3, 32'h0,         1'b0, 4'h0, 8'h00, 16'h0000, 32'h0, 32'h0},          // R7 reserved size
    '{4'd7, 1'b1, 1'b1, 2'd1, 2'd2, 32'hFFFF_FFFF, 1'b0, 4'h0, 8'h00, 16'h0000, 32'h0, 32'h0},          // R7 unaligned dword write
    '{4'd3, 1'b0, 1'b1, 2'd0, 2'd2, 32'h0000_0814, 1'b0, 4'h0, 8'h00, 16'h0000, 32'h0, 32'h0},          // R3 disable
    '{4'd3, 1'b1, 1'b0, 2'd0, 2'd2, 32'h0,         1'b0, 4'h0, 8'h00, 16'h0000, 32'h0, 32'h0},          // R3 read disabled
    '{4'd3, 1'b1, 1'b1, 2'd0, 2'd0, 32'h0000_0055, 1'b0, 4'h0, 8'h00, 16'h0000, 32'h0, 32'h0},          // R3 write disabled
    '{4'd4, 1'b0, 1'b1, 2'd0, 2'd2, 32'h8000_0815, 1'b0, 4'h0, 8'h00, 16'h0000, 32'h0, 32'h0},          // R4 misaligned latch
    '{4'd4, 1'b1, 1'b0, 2'd0, 2'd0, 32'h0,         1'b0, 4'h0, 8'h00, 16'h0000, 32'h0, 32'h0},          // R4 read rejected
    '{4'd1, 1'b0, 1'b0, 2'd0, 2'd2, 32'h0,         1'b0, 4'h0, 8'h00, 16'h0000, 32'h0, 32'h8000_0815}, // R1 low bits kept
    '{4'd5, 1'b0, 1'b1, 2'd0, 2'd2, 32'h8001_1020, 1'b0, 4'h0, 8'h00, 16'h0000, 32'h0, 32'h0},          // R5 bus 1 slot 0x10
    '{4'd5, 1'b1, 1'b0, 2'd0, 2'd2, 32'h0,         1'b1, 4'hF, 8'h20, 16'h0110, 32'h0, 32'h4433_2211}, // R5 present
    '{4'd5, 1'b0, 1'b1, 2'd0, 2'd2, 32'h8001_1120, 1'b0, 4'h0, 8'h00, 16'h0000, 32'h0, 32'h0},          // R5 slot 0x11
    '{4'd5, 1'b1, 1'b0, 2'd0, 2'd1, 32'h0,         1'b0, 4'h0, 8'h00, 16'h0000, 32'h0, 32'h0},          // R5 absent slot
    '{4'd5, 1'b0, 1'b1, 2'd0, 2'd2, 32'h8002_0820, 1'b0, 4'h0, 8'h00, 16'h0000, 32'h0, 32'h0},          // R5 bus 2
    '{4'd5, 1'b1, 1'b0, 2'd0, 2'd0, 32'h0,         1'b0, 4'h0, 8'h00, 16'h0000, 32'h0, 32'h0},          // R5 bus out of range
    '{4'd2, 1'b0, 1'b1, 2'd0, 2'd0, 32'hFFFF_FFFF, 1'b0, 4'h0, 8'h00, 16'h0000, 32'h0, 32'h0},          // R2 byte latch write
    '{4'd2, 1'b0, 1'b0, 2'd0, 2'd1, 32'h0,         1'b0, 4'h0, 8'h00, 16'h0000, 32'h0, 32'h0},          // R2 word latch read
    '{4'd2, 1'b0, 1'b0, 2'd0, 2'd2, 32'h0,         1'b0, 4'h0, 8'h00, 16'h0000, 32'h0, 32'h8002_0820}  // R2 latch unchanged
  };

  task automatic chk(input int rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v);
    logic s_sel;
    logic [3:0] s_be;
    logic [7:0] s_off;
    logic [15:0] s_idx;
    logic [31:0] s_twd;
    @(negedge clk);
    req_valid_i = 1'b1; req_port_i = v.port; req_write_i = v.we;
    req_addr_i = v.addr; req_size_i = v.size; req_wdata_i = v.wdata;
    #1;
    s_sel = tgt_sel_o; s_be = tgt_be_o; s_off = tgt_off_o;
    s_idx = {tgt_bus_o, tgt_devfn_o}; s_twd = tgt_wdata_o;
    @(negedge clk);
    req_valid_i = 1'b0;
    chk(int'(v.rq), "strobe", 32'(s_sel), 32'(v.sel));
    if (v.sel) begin
      chk(int'(v.rq), "byte enables", 32'(s_be), 32'(v.be));
      chk(int'(v.rq), "offset", 32'(s_off), 32'(v.off));
      chk(int'(v.rq), "bus/slot", 32'(s_idx), 32'(v.idx));
      if (v.we) chk(int'(v.rq), "lane write data", s_twd, v.twd);
    end
    chk(9, "rsp_valid", 32'(rsp_valid_o), 32'd1);  // R9
    chk(int'(v.rq), "read data", rsp_rdata_o, v.rdata);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R9 watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    present_i[{1'b0, 8'h08}] = 1'b1;
    present_i[{1'b1, 8'h10}] = 1'b1;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(10, "rsp_valid in reset", 32'(rsp_valid_o), 32'd0);
    chk(10, "rsp_rdata in reset", rsp_rdata_o, 32'd0);
    chk(9, "ready", 32'(req_ready_o), 32'd1);
    rst_ni = 1'b1;
    // R10 latch cleared: window read raises no strobe, latch reads 0
    run_vec('{4'd10, 1'b0, 1'b0, 2'd0, 2'd2, 32'h0, 1'b0, 4'h0, 8'h0, 16'h0, 32'h0, 32'h0});

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R9 idle cycle: no response
    @(negedge clk);
    chk(9, "rsp_valid idle", 32'(rsp_valid_o), 32'd0);

    // R10 mid-run reset clears latch
    run_vec('{4'd1, 1'b0, 1'b1, 2'd0, 2'd2, 32'h8000_0814, 1'b0, 4'h0, 8'h0, 16'h0, 32'h0, 32'h0});
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    chk(10, "rsp_valid after reset", 32'(rsp_valid_o), 32'd0);
    rst_ni = 1'b1;
    run_vec('{4'd10, 1'b1, 1'b0, 2'd0, 2'd0, 32'h0, 1'b0, 4'h0, 8'h0, 16'h0, 32'h0, 32'h0});
    run_vec('{4'd10, 1'b0, 1'b0, 2'd0, 2'd2, 32'h0, 1'b0, 4'h0, 8'h0, 16'h0, 32'h0, 32'h0});

    finish_run();
  end

endmodule